// File: doc/BRIEF.md
# Banked Mode Register Switcher

This block holds per-mode shadow copies of three CPU registers: the two highest general registers, here called GPA and GPB, and the saved-status register (STS). When the core changes operating mode, it presents a switch request with the target mode code and the current live values of those three registers. The block stores the live values in the bank that belongs to the mode being left. It then returns the contents of the bank that belongs to the mode being entered, and the core loads those values back into its live registers.

There are six mode codes and five banks, because two of the modes share one bank. A request for the mode that is already current writes no bank. A request with a code that is not one of the six known codes raises a one-cycle error pulse and changes nothing. The register file, the decode that produces switch requests and exception vectoring are all outside this block.

Top module: `bank_switch`

## Requirements
- R1: While reset is asserted and after it is released, every bank holds zero, the restore outputs are zero, done and error are low, and the current mode is privileged (code 5'h13).
- R2: The mode codes map to banks as follows. User (5'h10) and supervisor-user (5'h1F) both use bank 0. Privileged (5'h13) uses bank 1, trap (5'h17) bank 2, extension (5'h1B) bank 3 and interrupt (5'h12) bank 4. Any other value, including any value with a bit set above bit 4, is unknown.
- R3: A request with a known code that differs from the current mode writes the live GPA, GPB and STS values, as they were before the switch, into the bank of the outgoing mode.
- R4: The clock edge that samples a valid request makes the current mode equal to the requested code. At that same edge done pulses high, and the restore outputs show the incoming mode's bank contents as they stood before that edge.
- R5: A switch between two modes that share a bank returns the live values that were presented with the request.
- R6: A request for the current mode writes no bank. done still pulses, the restore outputs echo the live inputs, and the mode stays the same.
- R7: A request with an unknown code raises the error output for exactly one cycle. It gives no done pulse, writes no bank, and leaves the mode and the restore outputs unchanged.
- R8: done and error are single-cycle pulses and are never high together.
- R9: The restore outputs and the current mode hold their values in every cycle that does not carry a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Mode switch request, sampled each rising edge |
| req_mode_i | input | MODE_W | Requested mode code |
| live_gpa_i | input | DATA_W | Live value of the first banked general register |
| live_gpb_i | input | DATA_W | Live value of the second banked general register |
| live_sts_i | input | DATA_W | Live saved-status value |
| done_o | output | 1 | Pulse: switch accepted, restore outputs valid |
| err_o | output | 1 | Pulse: unknown mode code requested |
| cur_mode_o | output | MODE_W | Current mode code |
| rst_gpa_o | output | DATA_W | Restored first general register |
| rst_gpb_o | output | DATA_W | Restored second general register |
| rst_sts_o | output | DATA_W | Restored saved-status value |

## Verification
The bound checker watches every cycle for the following. The current mode must always be a known code. done and error must never coincide. The outputs must hold between done pulses. A request for the current mode must echo the live inputs. An unknown code must produce an error and keep the mode. A known code must produce done and adopt the new mode. Whether the right bank was written and later read back only shows up over a sequence of switches, so the bench walks a chain of switches. In that chain each value saved at one step is predicted to reappear several steps later. The chain covers the shared bank, the clearing of the banks by a mid-run reset, and unknown codes that must leave every bank as it was.

// File: rtl/bank_switch_pkg.sv
package bank_switch_pkg;
   localparam int NUM_BANKS   = 5;
   localparam int BIDX_W      = $clog2(NUM_BANKS);
   localparam int MODE_CODE_W = 5;

   localparam logic [MODE_CODE_W-1:0] MODE_USER = 5'h10;
   localparam logic [MODE_CODE_W-1:0] MODE_SUSR = 5'h1F;
   localparam logic [MODE_CODE_W-1:0] MODE_PRIV = 5'h13;
   localparam logic [MODE_CODE_W-1:0] MODE_TRAP = 5'h17;
   localparam logic [MODE_CODE_W-1:0] MODE_EXTN = 5'h1B;
   localparam logic [MODE_CODE_W-1:0] MODE_INTR = 5'h12;
endpackage

// File: rtl/bank_mode_decode.sv
module bank_mode_decode
   import bank_switch_pkg::*;
#(
   parameter int MODE_W = 5
) (
   input  logic [MODE_W-1:0] mode_i,
   output logic              valid_o,
   output logic [BIDX_W-1:0] bank_o
);
   logic [MODE_CODE_W-1:0] low_code;
   logic                   upper_zero;
   logic                   low_hit;

   assign low_code = mode_i[MODE_CODE_W-1:0];

   generate
      if (MODE_W > MODE_CODE_W) begin : g_wide
         assign upper_zero = ~|mode_i[MODE_W-1:MODE_CODE_W];
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      low_hit = 1'b1;
      bank_o  = '0;
      case (low_code)
         MODE_USER, MODE_SUSR: bank_o = BIDX_W'(0);
         MODE_PRIV:            bank_o = BIDX_W'(1);
         MODE_TRAP:            bank_o = BIDX_W'(2);
         MODE_EXTN:            bank_o = BIDX_W'(3);
         MODE_INTR:            bank_o = BIDX_W'(4);
         default:              low_hit = 1'b0;
      endcase
   end

   assign valid_o = low_hit & upper_zero;
endmodule

// File: rtl/bank_store.sv
module bank_store
   import bank_switch_pkg::*;
#(
   parameter int ENTRY_W = 96
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [BIDX_W-1:0]  wr_idx_i,
   input  logic [ENTRY_W-1:0] wr_data_i,
   input  logic [BIDX_W-1:0]  rd_idx_i,
   output logic [ENTRY_W-1:0] rd_data_o
);
   logic [NUM_BANKS-1:0][ENTRY_W-1:0] slot_flat;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
         logic [ENTRY_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_en_i && (wr_idx_i == BIDX_W'(b))) begin
               slot_q <= wr_data_i;
            end
         end
         assign slot_flat[b] = slot_q;
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_idx_i == BIDX_W'(b)) rd_data_o = slot_flat[b];
      end
   end
endmodule

// File: rtl/bank_switch.sv
module bank_switch
   import bank_switch_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int MODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [MODE_W-1:0] req_mode_i,
   input  logic [DATA_W-1:0] live_gpa_i,
   input  logic [DATA_W-1:0] live_gpb_i,
   input  logic [DATA_W-1:0] live_sts_i,
   output logic              done_o,
   output logic              err_o,
   output logic [MODE_W-1:0] cur_mode_o,
   output logic [DATA_W-1:0] rst_gpa_o,
   output logic [DATA_W-1:0] rst_gpb_o,
   output logic [DATA_W-1:0] rst_sts_o
);
   localparam int ENTRY_W = 3 * DATA_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("bank_switch: DATA_W must be at least 1");
      end
      if (MODE_W < MODE_CODE_W) begin : g_bad_mode
         $error("bank_switch: MODE_W too narrow for the mode codes");
      end
   endgenerate

   logic [MODE_W-1:0]  cur_mode_q;
   logic               req_known, cur_known;
   logic [BIDX_W-1:0]  req_bank, cur_bank;
   logic               same_mode, shared_bank, wr_en;
   logic [ENTRY_W-1:0] live_entry, bank_rd, restore_val, out_q;
   logic               done_q, err_q;

   bank_mode_decode #(.MODE_W(MODE_W)) u_req_dec (
      .mode_i (req_mode_i),
      .valid_o(req_known),
      .bank_o (req_bank)
   );

   bank_mode_decode #(.MODE_W(MODE_W)) u_cur_dec (
      .mode_i (cur_mode_q),
      .valid_o(cur_known),
      .bank_o (cur_bank)
   );

   assign live_entry  = {live_gpa_i, live_gpb_i, live_sts_i};
   assign same_mode   = (req_mode_i == cur_mode_q);
   assign shared_bank = (req_bank == cur_bank);
   assign wr_en       = req_i & req_known & cur_known & ~same_mode;
   assign restore_val = shared_bank ? live_entry : bank_rd;

   bank_store #(.ENTRY_W(ENTRY_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_idx_i (cur_bank),
      .wr_data_i(live_entry),
      .rd_idx_i (req_bank),
      .rd_data_o(bank_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_mode_q <= MODE_W'(MODE_PRIV);
         out_q      <= '0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (req_i) begin
            if (!req_known) begin
               err_q <= 1'b1;
            end else begin
               done_q     <= 1'b1;
               cur_mode_q <= req_mode_i;
               out_q      <= restore_val;
            end
         end
      end
   end

   assign done_o     = done_q;
   assign err_o      = err_q;
   assign cur_mode_o = cur_mode_q;
   assign {rst_gpa_o, rst_gpb_o, rst_sts_o} = out_q;
endmodule

// File: rtl/bank_switch_chk.sv
module bank_switch_chk
   import bank_switch_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int MODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [MODE_W-1:0] req_mode_i,
   input logic [DATA_W-1:0] live_gpa_i,
   input logic [DATA_W-1:0] live_gpb_i,
   input logic [DATA_W-1:0] live_sts_i,
   input logic              done_o,
   input logic              err_o,
   input logic [MODE_W-1:0] cur_mode_o,
   input logic [DATA_W-1:0] rst_gpa_o,
   input logic [DATA_W-1:0] rst_gpb_o,
   input logic [DATA_W-1:0] rst_sts_o
);
   function automatic logic is_known(logic [MODE_W-1:0] m);
      return (m == MODE_W'(MODE_USER)) || (m == MODE_W'(MODE_SUSR)) ||
             (m == MODE_W'(MODE_PRIV)) || (m == MODE_W'(MODE_TRAP)) ||
             (m == MODE_W'(MODE_EXTN)) || (m == MODE_W'(MODE_INTR));
   endfunction

   p_mode_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_known(cur_mode_o));

   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(rst_gpa_o) && $stable(rst_gpb_o) &&
                   $stable(rst_sts_o) && $stable(cur_mode_o)));

   p_unknown_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !is_known(req_mode_i)) |=> (err_o && !done_o && $stable(cur_mode_o)));

   p_switch_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && is_known(req_mode_i)) |=> (done_o && cur_mode_o == $past(req_mode_i)));

   p_same_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && req_mode_i == cur_mode_o) |=>
         (rst_gpa_o == $past(live_gpa_i) && rst_gpb_o == $past(live_gpb_i) &&
          rst_sts_o == $past(live_sts_i)));
endmodule

bind bank_switch bank_switch_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_mode_i(req_mode_i),
   .live_gpa_i(live_gpa_i), .live_gpb_i(live_gpb_i), .live_sts_i(live_sts_i),
   .done_o(done_o), .err_o(err_o), .cur_mode_o(cur_mode_o),
   .rst_gpa_o(rst_gpa_o), .rst_gpb_o(rst_gpb_o), .rst_sts_o(rst_sts_o)
);

// File: tb/tb_bank_switch.sv
module tb_bank_switch;
   localparam int DW = 32;
   localparam int MW = 5;
   localparam int NSTEP = 13;

   // stimulus: requested mode; expected: error flag, source step of restored data, mode after
   localparam int V_MODE [NSTEP] = '{'h17, 'h12, 'h13, 'h10, 'h1F, 'h17, 'h05,
                                     'h17, 'h12, 'h10, 'h1B, 'h17, 'h1B};
   localparam int V_ERR  [NSTEP] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
   localparam int V_SRC  [NSTEP] = '{0, 0, 1, 0, 5, 2, 2, 8, 3, 6, 0, 9, 12};
   localparam int V_NMOD [NSTEP] = '{'h17, 'h12, 'h13, 'h10, 'h1F, 'h17, 'h17,
                                     'h17, 'h12, 'h10, 'h1B, 'h17, 'h1B};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic [MW-1:0] mode = '0;
   logic [DW-1:0] gpa = '0, gpb = '0, sts = '0;
   logic done, err;
   logic [MW-1:0] cur_mode;
   logic [DW-1:0] o_gpa, o_gpb, o_sts;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bank_switch #(.DATA_W(DW), .MODE_W(MW)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_mode_i(mode),
      .live_gpa_i(gpa), .live_gpb_i(gpb), .live_sts_i(sts),
      .done_o(done), .err_o(err), .cur_mode_o(cur_mode),
      .rst_gpa_o(o_gpa), .rst_gpb_o(o_gpb), .rst_sts_o(o_sts)
   );

   function automatic logic [DW-1:0] pat(int src, int which);
      if (src == 0) return '0;
      return DW'(32'hA000_0000 + which * 32'h1000_0000 + src);
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_out(string tag, int src);
      chk({tag, " gpa"}, o_gpa, pat(src, 0));
      chk({tag, " gpb"}, o_gpb, pat(src, 1));
      chk({tag, " sts"}, o_sts, pat(src, 2));
   endtask

   task automatic request(int m, int src);
      @(negedge clk);
      req = 1'b1; mode = MW'(m);
      gpa = pat(src, 0); gpb = pat(src, 1); sts = pat(src, 2);
      @(negedge clk);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mode in reset", DW'(cur_mode), DW'(5'h13));
      chk("R1 done in reset", DW'(done), 0);
      chk_out("R1 outputs in reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode after release", DW'(cur_mode), DW'(5'h13));

      // chain of switches: R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NSTEP; i++) begin
         request(V_MODE[i], i + 1);
         chk($sformatf("R4 step %0d done", i), DW'(done), DW'(V_ERR[i] == 0));
         chk($sformatf("R7 step %0d err", i), DW'(err), DW'(V_ERR[i]));
         chk($sformatf("R2 step %0d mode", i), DW'(cur_mode), DW'(V_NMOD[i]));
         chk_out($sformatf("R3 R5 R6 step %0d restore", i), V_SRC[i]);
         req = 1'b0;
      end

      // R8 R9 pulses drop and outputs hold
      @(negedge clk);
      chk("R8 done drops", DW'(done), 0);
      chk("R8 err drops", DW'(err), 0);
      chk("R9 mode holds", DW'(cur_mode), DW'(5'h1B));
      chk_out("R9 outputs hold", 12);

      // R7 wide-range unknown code, then one-cycle pulse
      request('h1C, 20);
      req = 1'b0;
      chk("R7 err on 1C", DW'(err), 1);
      chk("R7 mode kept", DW'(cur_mode), DW'(5'h1B));
      chk_out("R7 outputs kept", 12);
      @(negedge clk);
      chk("R8 err single cycle", DW'(err), 0);

      // R1 mid-run reset clears the banks
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode after mid reset", DW'(cur_mode), DW'(5'h13));
      chk_out("R1 outputs after mid reset", 0);
      request('h17, 30);
      req = 1'b0;
      chk_out("R1 trap bank cleared", 0);
      request('h13, 31);
      req = 1'b0;
      chk_out("R1 R3 priv bank after reset", 30);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule